// File: doc/BRIEF.md
# Fuzzy Misuse Level Inference Engine

This block turns a small set of integer sensor counters into a single misuse level. Each counter arrives with its own full-scale value, a multiple of five. The counter is placed in one of five equal slices of its range and given a degree in each of eight fixed linguistic subsets. A programmable table of up to twelve rules combines these degrees with min (AND), max (OR) and complement (NOT). Each rule concludes either LOW or HIGH misuse. The strongest LOW premise and the strongest HIGH premise are then mapped to an 8-bit level through a fixed first-of-maximum table.

All degrees are 3-bit ordered indices into a seven-value set, so fuzzy min and max reduce to integer compares and complement reduces to a subtraction. Software loads rule words through a simple write port. A one-cycle start pulse triggers one evaluation, and a one-cycle done pulse marks the new level.

Top module: `fuzzy_misuse_engine`

## Requirements
- R1: A start pulse sampled on a rising edge raises done for exactly the next cycle, and the new level appears in that same cycle. Done is never high in a cycle that does not follow a start.
- R2: Interval choice uses the value v and maximum m. Interval k (1..5) is the first for which 5·v <= k·m. Each upper bound is inclusive, and a value above m falls in interval 5.
- R3: Degree codes are 0..6, meaning 0, 1/4, 1/3, 1/2, 2/3, 3/4 and 1. Subset codes are 0 rather-low, 1 low, 2 very-low, 3 very-very-low, 4 very-very-high, 5 very-high, 6 high, 7 rather-high. Per interval, the degrees for subsets 0..7 are: interval 1: 6,6,6,6,0,0,0,0; interval 2: 5,4,3,0,0,0,0,1; interval 3: 3,2,0,0,0,0,2,3; interval 4: 1,0,0,0,0,3,4,5; interval 5: 0,0,0,0,6,6,6,6.
- R4: A negated term has degree 6 minus its membership code.
- R5: With two terms, the premise is the min of the two degrees for AND and the max for OR. With one term, the premise is term A alone, whatever the operator bit says.
- R6: The rule word is 20 bits: [2:0] subset A, [3] negate A, [7:4] input A, [10:8] subset B, [11] negate B, [15:12] input B, [16] use term B, [17] operator (1 = OR), [18] conclusion (1 = HIGH), [19] enable.
- R7: The LOW degree is the max premise over enabled LOW rules, and the HIGH degree is the max over enabled HIGH rules. With no enabled rule of a kind, that degree is 0.
- R8: Level codes for HIGH degrees 1..6 are 90, 102, 128, 154, 166 and 205; these are fractions of 256. The output rules are: a LOW degree of 6 gives 0; a LOW degree of 4 or 5 gives 205 only when the HIGH degree is 6, and 0 otherwise; a LOW degree of 0..3 gives the HIGH code when the HIGH degree exceeds the LOW degree, and 0 otherwise.
- R9: Reset clears all rules, done and level. Level holds its value between evaluations, even while the inputs change.
- R10: A write to an address of N_RULES or above changes nothing. A term that selects an input index of N_IN or above has degree 0, negated or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_addr | input | $clog2(N_RULES) | Rule slot to write |
| cfg_wdata | input | 20 | Rule word |
| in_val | input | N_IN*CW | Packed sensor counters, input i at bits [i*CW +: CW] |
| in_max | input | N_IN*CW | Packed full-scale values, same packing |
| start | input | 1 | Evaluation request |
| done | output | 1 | One-cycle result strobe |
| level | output | 8 | Misuse level, fraction of 256 |

## Verification
The bench uses the default parameters: four 8-bit inputs and twelve rule slots. The 4-bit input-select field can therefore name inputs 4 to 15, which do not exist. The 4-bit address can reach slots 12 to 15, which are past the last rule. Two full-scale values, 10 and 20, make it possible to place counters exactly on interval bounds and just above them. These settings let every row class of the output table be reached with only two or three rules.

// File: rtl/fuzzy_misuse_engine.sv
module fuzzy_misuse_engine #(
  parameter int N_IN    = 4,
  parameter int CW      = 8,
  parameter int N_RULES = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(N_RULES)-1:0] cfg_addr,
  input  logic [19:0]              cfg_wdata,
  input  logic [N_IN*CW-1:0]       in_val,
  input  logic [N_IN*CW-1:0]       in_max,
  input  logic                     start,
  output logic                     done,
  output logic [7:0]               level
);
  localparam int RW = 20;
  localparam int EW = CW + 3;

  logic [RW-1:0] rules [N_RULES];
  logic [2:0]    pl, ph;

  function automatic logic [2:0] member(input logic [CW-1:0] v, input logic [CW-1:0] m,
                                        input logic [2:0] sub);
    logic [EW-1:0] v5;
    logic [23:0]   row;
    v5 = EW'(v) * EW'(5);
    if      (v5 <= EW'(m))            row = {3'd0,3'd0,3'd0,3'd0,3'd6,3'd6,3'd6,3'd6};
    else if (v5 <= EW'(m) * EW'(2))   row = {3'd1,3'd0,3'd0,3'd0,3'd0,3'd3,3'd4,3'd5};
    else if (v5 <= EW'(m) * EW'(3))   row = {3'd3,3'd2,3'd0,3'd0,3'd0,3'd0,3'd2,3'd3};
    else if (v5 <= EW'(m) * EW'(4))   row = {3'd5,3'd4,3'd3,3'd0,3'd0,3'd0,3'd0,3'd1};
    else                              row = {3'd6,3'd6,3'd6,3'd6,3'd0,3'd0,3'd0,3'd0};
    return row[sub*3 +: 3];
  endfunction

  function automatic logic [2:0] term(input logic [3:0] sel, input logic neg,
                                      input logic [2:0] sub,
                                      input logic [N_IN*CW-1:0] vals,
                                      input logic [N_IN*CW-1:0] maxs);
    logic [2:0] d;
    d = 3'd0;
    for (int i = 0; i < N_IN; i++)
      if (sel == 4'(i)) begin
        d = member(vals[i*CW +: CW], maxs[i*CW +: CW], sub);
        d = neg ? 3'd6 - d : d;
      end
    return d;
  endfunction

  function automatic logic [7:0] lut(input logic [2:0] l, input logic [2:0] h);
    logic [7:0] v;
    case (h)
      3'd1: v = 8'd90;
      3'd2: v = 8'd102;
      3'd3: v = 8'd128;
      3'd4: v = 8'd154;
      3'd5: v = 8'd166;
      3'd6: v = 8'd205;
      default: v = 8'd0;
    endcase
    if (l >= 3'd6)      return 8'd0;
    else if (l >= 3'd4) return (h == 3'd6) ? 8'd205 : 8'd0;
    else                return (h > l) ? v : 8'd0;
  endfunction

  always_comb begin
    pl = 3'd0;
    ph = 3'd0;
    for (int r = 0; r < N_RULES; r++) begin
      logic [2:0] da, db, pr;
      da = term(rules[r][7:4], rules[r][3], rules[r][2:0], in_val, in_max);
      db = term(rules[r][15:12], rules[r][11], rules[r][10:8], in_val, in_max);
      if (!rules[r][16])     pr = da;
      else if (rules[r][17]) pr = (da > db) ? da : db;
      else                   pr = (da < db) ? da : db;
      if (rules[r][19]) begin
        if (rules[r][18]) begin
          if (pr > ph) ph = pr;
        end else begin
          if (pr > pl) pl = pr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < N_RULES; r++) rules[r] <= '0;
    end else if (cfg_we && int'(cfg_addr) < N_RULES) begin
      rules[cfg_addr] <= cfg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done  <= 1'b0;
      level <= 8'd0;
    end else begin
      done <= start;
      if (start) level <= lut(pl, ph);
    end

  a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(level));
  a_r7_degree_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pl <= 3'd6) && (ph <= 3'd6));
  a_r8_full_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pl == 3'd6) |=> level == 8'd0);
  a_r8_level_codes: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (level inside {8'd0, 8'd90, 8'd102, 8'd128, 8'd154, 8'd166, 8'd205}));
endmodule

// File: tb/sim_fuzzy_misuse_engine.sv
module sim_fuzzy_misuse_engine;
  localparam int N_IN = 4, CW = 8, N_RULES = 12;

  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0;
  logic [3:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [N_IN*CW-1:0] in_val = '0, in_max = '0;
  logic done;
  logic [7:0] level;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fuzzy_misuse_engine #(.N_IN(N_IN), .CW(CW), .N_RULES(N_RULES)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_val(in_val), .in_max(in_max),
    .start(start), .done(done), .level(level));

  function automatic logic [19:0] rule(input bit en, input bit hi, input bit orop,
      input bit useb, input int selb, input bit negb, input int subb,
      input int sela, input bit nega, input int suba);
    return {en, hi, orop, useb, 4'(selb), negb, 3'(subb), 4'(sela), nega, 3'(suba)};
  endfunction

  function automatic logic [19:0] one(input bit hi, input int sel, input bit neg, input int sub);
    return rule(1, hi, 0, 0, 0, 0, 0, sel, neg, sub);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < N_RULES; r++) wr(r, '0);
  endtask

  task automatic set_in(input int i, input int v, input int m);
    in_val[i*CW +: CW] = CW'(v);
    in_max[i*CW +: CW] = CW'(m);
  endtask

  task automatic eval(input string req, input int exp);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk({req, " done"}, int'(done), 1);
    chk(req, int'(level), exp);
    @(negedge clk);
    chk({req, " done drop"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset level", int'(level), 0);
    eval("R7 no rules", 0);
  endtask

  task automatic t_fuzzify();
    set_in(0, 3, 10);
    wr(0, one(1, 0, 0, 7)); eval("R3 3/10 rather-high", 90);
    wr(0, one(1, 0, 0, 2)); eval("R3 3/10 very-low", 128);
    set_in(0, 7, 10);
    wr(0, one(1, 0, 0, 6)); eval("R3 7/10 high", 154);
    wr(0, one(1, 0, 0, 3)); eval("R3 7/10 very-very-low", 0);
  endtask

  task automatic t_intervals();
    wr(0, one(1, 0, 0, 6));
    set_in(0, 2, 10);  eval("R2 v=2", 0);
    set_in(0, 4, 10);  eval("R2 v=4 bound", 0);
    set_in(0, 5, 10);  eval("R2 v=5", 102);
    set_in(0, 6, 10);  eval("R2 v=6 bound", 102);
    set_in(0, 8, 10);  eval("R2 v=8 bound", 154);
    set_in(0, 9, 10);  eval("R2 v=9", 205);
    set_in(0, 15, 10); eval("R2 v above max", 205);
  endtask

  task automatic t_not();
    wr(0, one(1, 0, 1, 6));
    set_in(0, 8, 10); eval("R4 not 2/3", 102);
    set_in(0, 2, 10); eval("R4 not 0", 205);
    set_in(0, 5, 10); eval("R4 not 1/3", 154);
  endtask

  task automatic t_ops();
    set_in(0, 8, 10); set_in(1, 3, 10);
    wr(0, rule(1, 1, 0, 1, 1, 0, 7, 0, 0, 6)); eval("R5 AND min", 90);
    wr(0, rule(1, 1, 1, 1, 1, 0, 7, 0, 0, 6)); eval("R5 OR max", 154);
    set_in(0, 3, 10);
    wr(0, rule(1, 1, 1, 0, 1, 0, 7, 0, 0, 6)); eval("R5 single term", 0);
    wr(0, rule(1, 1, 1, 1, 1, 0, 7, 0, 0, 6)); eval("R6 use-B bit", 90);
  endtask

  task automatic t_aggregate();
    clear_all();
    set_in(0, 5, 10); set_in(3, 8, 10);
    wr(0, one(1, 0, 0, 6));
    wr(2, one(1, 3, 0, 5));
    eval("R7 max of HIGH rules", 128);
    wr(2, rule(0, 1, 0, 0, 0, 0, 0, 3, 0, 5));
    eval("R7 disabled rule", 102);
  endtask

  task automatic t_table();
    clear_all();
    wr(0, one(1, 0, 0, 6));
    wr(1, one(0, 2, 0, 0));
    set_in(0, 8, 10); set_in(2, 10, 20); eval("R8 pl=1/2 ph=2/3", 154);
    set_in(2, 16, 20); eval("R8 pl=1/4 ph=2/3", 154);
    set_in(0, 5, 10); set_in(2, 10, 20); eval("R8 ph below pl", 0);
    wr(1, one(0, 2, 0, 1)); eval("R8 ph equals pl", 0);
    set_in(2, 6, 20); set_in(0, 8, 10); eval("R8 pl=2/3 ph=2/3", 0);
    set_in(0, 10, 10); eval("R8 pl=2/3 ph=1", 205);
    set_in(2, 0, 20); eval("R8 pl=1", 0);
  endtask

  task automatic t_ignore();
    clear_all();
    set_in(0, 10, 10);
    wr(0, one(1, 0, 0, 6)); eval("R10 baseline", 205);
    wr(0, one(1, 5, 0, 6)); eval("R10 missing input", 0);
    wr(0, one(1, 5, 1, 6)); eval("R10 missing input negated", 0);
    wr(12, one(1, 0, 0, 6)); eval("R10 write past last slot", 0);
    wr(15, one(1, 0, 0, 6)); eval("R10 write slot 15", 0);
  endtask

  task automatic t_hold();
    clear_all();
    set_in(0, 10, 10);
    wr(0, one(1, 0, 0, 6)); eval("R1 eval", 205);
    set_in(0, 0, 10);
    repeat (4) @(negedge clk);
    chk("R9 level holds", int'(level), 205);
    chk("R1 no done without start", int'(done), 0);
    eval("R1 re-eval", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fuzzify();
    t_intervals();
    t_not();
    t_ops();
    t_aggregate();
    t_table();
    t_ignore();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule